// File: doc/BRIEF.md
# Record Channel Pulse Sequencer

This block produces the switch controls for a nine-channel record head built from eight main data channels and one auxiliary channel. A 32-bit record word arrives serially, one bit per tape-clock cycle. The three leading bits select the record mode. The next nine bits give the current direction of each channel. The rest of the word is not used. Each word is captured while it arrives and takes effect for the whole of the following word period. During that period the channels are driven one after another. A driven channel closes the high-side (P) switch on one of its two head nodes and the low-side (N) switch on the other node. All other switches stay open, so those outputs float.

The head has ten nodes in a row, numbered 0 to 9. Channel k sits between node k and node k+1. Channel 0 is the auxiliary channel and channels 1 to 8 are main data channels 0 to 7. Neighbouring channels therefore share a node. Alongside the switches the block outputs a current-scale select, which tells the analog current source whether to deliver the normal main-data level, the boosted auxiliary write level or the boosted erase level. It also outputs a standby flag. Standby is held in a latch that the standby pin can force on at any time. Once the pin is released, the latch clears only when a word arrives that asks for recording.

A single controller sets the order of operation and has four states. ST_STBY means everything is open. ST_DRIVE means the selected channel is driven. ST_GAP is a dead interval between two channels. ST_REST covers the idle tail of the word. The transitions are these:
- A high standby pin moves any state to ST_STBY.
- At a word boundary the controller enters ST_STBY if the new word sets both playback bits. Otherwise it enters ST_DRIVE at channel 0.
- ST_DRIVE moves to ST_GAP after the active cycles.
- ST_GAP moves to ST_DRIVE for the next channel after the dead cycles, or to ST_REST after the last channel.
- ST_REST and ST_STBY hold until the next boundary.

Top module: `rec_pulse_seq`

## Requirements
- R1: While reset is asserted, `standby` is 1, all P and N enables are 0 and `cur_scale` is 0 (off).
- R2: After reset the word counter starts at position 0. Bit k of a word is sampled at the clock edge that ends word position k. Positions 0 to 31 form one word. Bit 0 is main-data playback, bit 1 is aux playback, bit 2 is aux erase, bits 3 to 10 are the directions of main channels 0 to 7 and bit 11 is the aux direction (1 = forward). Bits 12 to 31 are ignored. A word governs the outputs for the whole of the next word period.
- R3: Within a word period, channel c (0 = aux, 1 to 8 = main 0 to 7) may be driven at positions 3c and 3c+1. Position 3c+2 and positions 27 to 31 leave every switch open.
- R4: A forward drive of channel c closes P[c] and N[c+1]. A reverse drive closes P[c+1] and N[c]. No other switch is closed.
- R5: If the main playback bit is 1, the main channel slots stay open. If the aux playback bit is 1, the aux slot stays open.
- R6: A word with both playback bits set to 1 puts the block in standby: `standby` is 1 and every switch is open for the following word period.
- R7: A high `wstby` gives `standby` = 1 with all switches open in the same cycle.
- R8: After `wstby` falls, standby continues until the next word boundary at which a loaded word has at least one playback bit at 0.
- R9: While erasing (aux erase bit 1 and aux playback bit 0), the aux direction bit is ignored. An internal polarity flag starts at 0 on reset and toggles at every word boundary. The aux channel is driven forward when the flag is 1 and reversed when it is 0, so the erase polarity alternates from word to word.
- R10: `cur_scale` is 1 while a main channel is driven, 2 while aux is driven for writing, 3 while aux is driven for erasing, and 0 whenever no switch is closed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tape clock, one word bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| wdata | input | 1 | Serial record word |
| wstby | input | 1 | Standby force pin, active high |
| p_en | output | 10 | High-side switch enables, one per head node |
| n_en | output | 10 | Low-side switch enables, one per head node |
| cur_scale | output | 2 | Current scale: 0 off, 1 normal, 2 aux write, 3 aux erase |
| standby | output | 1 | Record part in standby |

## Verification
The assertions assume that `wstby` and `wdata` change only between clock edges and that word timing is set by reset alone, with no external frame marker. Under those assumptions, the break-before-make check between channels and the one-hot switch checks rely only on the controller's own counting. The stimulus changes both inputs on the falling clock edge and keeps `wstby` high from reset until the first words have passed. It later applies one short `wstby` pulse in the middle of an active word, so that both the forced standby and the held standby appear at known word positions.

// File: rtl/rec_seq_pkg.sv
package rec_seq_pkg;

    typedef enum logic [1:0] {
        SC_OFF   = 2'd0,
        SC_NORM  = 2'd1,
        SC_WRITE = 2'd2,
        SC_ERASE = 2'd3
    } scale_e;

    typedef enum logic [1:0] {
        ST_STBY  = 2'd0,
        ST_DRIVE = 2'd1,
        ST_GAP   = 2'd2,
        ST_REST  = 2'd3
    } seq_state_e;

    localparam int BIT_MAIN_PB = 0;
    localparam int BIT_AUX_PB  = 1;
    localparam int BIT_ERASE   = 2;
    localparam int MODE_BITS   = 3;

endpackage

// File: rtl/rec_word_capture.sv
module rec_word_capture #(
    parameter int WORD_LEN = 32,
    parameter int HOLD_W   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wdata,
    output logic              boundary,
    output logic [HOLD_W-1:0] hold,
    output logic [HOLD_W-1:0] word_q
);
    localparam int CW = $clog2(WORD_LEN);

    logic [CW-1:0] wpos;

    assign boundary = (wpos == CW'(WORD_LEN - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wpos <= '0;
        end else if (boundary) begin
            wpos <= '0;
        end else begin
            wpos <= wpos + 1'b1;
        end
    end

    for (genvar i = 0; i < HOLD_W; i++) begin : g_hold
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hold[i] <= 1'b0;
            end else if (wpos == CW'(i)) begin
                hold[i] <= wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (boundary) begin
            word_q <= hold;
        end
    end

endmodule

// File: rtl/rec_slot_fsm.sv
module rec_slot_fsm
    import rec_seq_pkg::*;
#(
    parameter int NCH       = 9,
    parameter int SLOT_ACT  = 2,
    parameter int SLOT_DEAD = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   boundary,
    input  logic                   wstby,
    input  logic                   pend_stby,
    output logic                   drive,
    output logic [$clog2(NCH)-1:0] chan,
    output logic                   standby,
    output logic                   pol
);
    localparam int CHW = $clog2(NCH);
    localparam int PHW = $clog2(SLOT_ACT + SLOT_DEAD + 1);

    seq_state_e     state, state_nx;
    logic [CHW-1:0] ch_nx;
    logic [PHW-1:0] ph, ph_nx;

    always_comb begin
        state_nx = state;
        ch_nx    = chan;
        ph_nx    = ph;
        if (wstby) begin
            state_nx = ST_STBY;
        end else if (boundary) begin
            state_nx = pend_stby ? ST_STBY : ST_DRIVE;
            ch_nx    = '0;
            ph_nx    = '0;
        end else begin
            unique case (state)
                ST_DRIVE: begin
                    if (ph == PHW'(SLOT_ACT - 1)) begin
                        state_nx = ST_GAP;
                        ph_nx    = '0;
                    end else begin
                        ph_nx = ph + 1'b1;
                    end
                end
                ST_GAP: begin
                    if (ph == PHW'(SLOT_DEAD - 1)) begin
                        ph_nx = '0;
                        if (chan == CHW'(NCH - 1)) begin
                            state_nx = ST_REST;
                        end else begin
                            state_nx = ST_DRIVE;
                            ch_nx    = chan + 1'b1;
                        end
                    end else begin
                        ph_nx = ph + 1'b1;
                    end
                end
                ST_REST: state_nx = ST_REST;
                ST_STBY: state_nx = ST_STBY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_STBY;
            chan  <= '0;
            ph    <= '0;
            pol   <= 1'b0;
        end else begin
            state <= state_nx;
            chan  <= ch_nx;
            ph    <= ph_nx;
            if (boundary) begin
                pol <= ~pol;
            end
        end
    end

    always_comb begin
        drive   = (state == ST_DRIVE) && !wstby;
        standby = (state == ST_STBY) || wstby;
    end

endmodule

// File: rtl/rec_switch_map.sv
module rec_switch_map #(
    parameter int NCH = 9
) (
    input  logic                   drive,
    input  logic [$clog2(NCH)-1:0] chan,
    input  logic                   fwd,
    output logic [NCH:0]           p_en,
    output logic [NCH:0]           n_en
);
    for (genvar j = 0; j <= NCH; j++) begin : g_node
        logic is_lo, is_hi;
        assign is_lo   = (int'(chan) == j);
        assign is_hi   = (int'(chan) + 1 == j);
        assign p_en[j] = drive && ((is_lo && fwd) || (is_hi && !fwd));
        assign n_en[j] = drive && ((is_hi && fwd) || (is_lo && !fwd));
    end

endmodule

// File: rtl/rec_pulse_seq.sv
module rec_pulse_seq
    import rec_seq_pkg::*;
#(
    parameter int NMAIN     = 8,
    parameter int WORD_LEN  = 32,
    parameter int SLOT_ACT  = 2,
    parameter int SLOT_DEAD = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wdata,
    input  logic             wstby,
    output logic [NMAIN+1:0] p_en,
    output logic [NMAIN+1:0] n_en,
    output logic [1:0]       cur_scale,
    output logic             standby
);
    localparam int NCH      = NMAIN + 1;
    localparam int CHW      = $clog2(NCH);
    localparam int DIR_BASE = MODE_BITS;
    localparam int HOLD_W   = MODE_BITS + NCH;
    localparam int AUX_DIR  = DIR_BASE + NMAIN;

    logic              boundary;
    logic [HOLD_W-1:0] hold, word_q;
    logic              drive, pol, fwd, sel_aux, chan_en, drive_on, erasing;
    logic [CHW-1:0]    chan;
    logic [NCH-1:0]    dir_vec;
    scale_e            scale;

    rec_word_capture #(.WORD_LEN(WORD_LEN), .HOLD_W(HOLD_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .wdata(wdata),
        .boundary(boundary), .hold(hold), .word_q(word_q)
    );

    rec_slot_fsm #(.NCH(NCH), .SLOT_ACT(SLOT_ACT), .SLOT_DEAD(SLOT_DEAD)) u_fsm (
        .clk(clk), .rst_n(rst_n), .boundary(boundary), .wstby(wstby),
        .pend_stby(hold[BIT_MAIN_PB] & hold[BIT_AUX_PB]),
        .drive(drive), .chan(chan), .standby(standby), .pol(pol)
    );

    assign erasing = word_q[BIT_ERASE];
    assign sel_aux = (chan == '0);
    assign dir_vec = {word_q[DIR_BASE +: NMAIN], erasing ? pol : word_q[AUX_DIR]};
    assign fwd     = dir_vec[chan];
    assign chan_en = sel_aux ? !word_q[BIT_AUX_PB] : !word_q[BIT_MAIN_PB];
    assign drive_on = drive && chan_en;

    always_comb begin
        if (!drive_on) begin
            scale = SC_OFF;
        end else if (!sel_aux) begin
            scale = SC_NORM;
        end else begin
            scale = erasing ? SC_ERASE : SC_WRITE;
        end
    end

    assign cur_scale = scale;

    rec_switch_map #(.NCH(NCH)) u_map (
        .drive(drive_on), .chan(chan), .fwd(fwd),
        .p_en(p_en), .n_en(n_en)
    );

endmodule

// File: rtl/rec_pulse_seq_chk.sv
module rec_pulse_seq_chk #(
    parameter int NNODE = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wstby,
    input logic [NNODE-1:0] p_en,
    input logic [NNODE-1:0] n_en,
    input logic [1:0]       cur_scale,
    input logic             standby
);
    // R4: one high-side and one low-side switch at most, always as a pair
    a_r4_single_pair: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(p_en) && $onehot0(n_en) && ($countones(p_en) == $countones(n_en)));

    // R4: never both switches of the same node
    a_r4_no_shoot: assert property (@(posedge clk) disable iff (!rst_n)
        (p_en & n_en) == '0);

    // R10: scale is off exactly when nothing is closed
    a_r10_scale_off: assert property (@(posedge clk) disable iff (!rst_n)
        (p_en == '0) == (cur_scale == 2'd0));

    // R7: pin forces standby with all outputs open
    a_r7_pin_forces: assert property (@(posedge clk) disable iff (!rst_n)
        wstby |-> (standby && p_en == '0 && n_en == '0));

    // R8: standby still held in the cycle the pin is released
    a_r8_hold_after_pin: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wstby) |-> standby);

    // R6: standby means every switch open
    a_r6_standby_open: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> (p_en == '0 && n_en == '0 && cur_scale == 2'd0));

    // R3: consecutive driven cycles belong to the same channel (break before make)
    a_r3_break_before_make: assert property (@(posedge clk) disable iff (!rst_n)
        (p_en != '0 && $past(p_en) != '0) |-> (p_en == $past(p_en) && n_en == $past(n_en)));

endmodule

bind rec_pulse_seq rec_pulse_seq_chk #(.NNODE(NMAIN + 2)) u_chk (
    .clk(clk), .rst_n(rst_n), .wstby(wstby), .p_en(p_en), .n_en(n_en),
    .cur_scale(cur_scale), .standby(standby)
);

// File: tb/rec_pulse_seq_tb.sv
module rec_pulse_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NWORDS     = 13;
    localparam int PULSE_AT   = 8 * 32 + 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wdata = 1'b0;
    logic       wstby = 1'b0;
    logic [9:0] p_en, n_en;
    logic [1:0] cur_scale;
    logic       standby;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rec_pulse_seq u_dut (
        .clk(clk), .rst_n(rst_n), .wdata(wdata), .wstby(wstby),
        .p_en(p_en), .n_en(n_en), .cur_scale(cur_scale), .standby(standby)
    );

    int          checks = 0;
    int          errors = 0;
    int          bcyc = 0;
    logic [31:0] words [NWORDS];
    bit          m_stby = 1'b1;
    bit          m_pol = 1'b0;
    logic [11:0] m_cap = '0;
    logic [11:0] m_cur = '0;

    function automatic logic [31:0] mkw(bit dp, bit ap, bit er, logic [7:0] mdir, bit adir);
        return {20'hABCDE, adir, mdir, er, ap, dp};
    endfunction

    // Behavioural model: word position, captured bits, standby latch, erase polarity
    always @(posedge clk) begin
        int pos;
        if (rst_n) begin
            pos = bcyc % 32;
            if (pos < 12) m_cap[pos] = wdata;
            if (wstby) m_stby = 1'b1;
            if (pos == 31) begin
                m_cur  = m_cap;
                m_pol  = ~m_pol;
                m_stby = wstby || (m_cap[0] && m_cap[1]);
            end
            bcyc++;
        end
    end

    task automatic drive_inputs();
        int w = bcyc / 32;
        wdata = (w < NWORDS) ? words[w][bcyc % 32] : ((bcyc % 32) < 2);
        wstby = (bcyc < 40) || (bcyc >= PULSE_AT && bcyc < PULSE_AT + 3);
    endtask

    task automatic check_cycle();
        logic [9:0] ep = '0;
        logic [9:0] en = '0;
        logic [1:0] es = 2'd0;
        bit         est;
        bit         dir;
        string      tag;
        int pos = bcyc % 32;
        int c   = pos / 3;
        int ph  = pos % 3;
        if (wstby) begin
            est = 1'b1; tag = "R7";
        end else if (m_stby) begin
            est = 1'b1; tag = "R6/R8";
        end else begin
            est = 1'b0; tag = "R2/R3/R5";
            if (c < 9 && ph < 2 && ((c == 0) ? !m_cur[1] : !m_cur[0])) begin
                dir = (c == 0) ? (m_cur[2] ? m_pol : m_cur[11]) : m_cur[3 + c - 1];
                if (dir) begin ep[c] = 1'b1; en[c + 1] = 1'b1; end
                else     begin ep[c + 1] = 1'b1; en[c] = 1'b1; end
                es  = (c == 0) ? (m_cur[2] ? 2'd3 : 2'd2) : 2'd1;
                tag = (c == 0) ? (m_cur[2] ? "R9/R10" : "R4/R10") : "R3/R4/R10";
            end
        end
        checks++;
        if (p_en !== ep || n_en !== en || cur_scale !== es || standby !== est) begin
            errors++;
            $display("FAIL %s pos=%0d actual p=%b n=%b s=%0d st=%b expected p=%b n=%b s=%0d st=%b",
                     tag, bcyc, p_en, n_en, cur_scale, standby, ep, en, es, est);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL R3 watchdog actual=timeout expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        words[0]  = mkw(0, 0, 0, 8'hA5, 1);   // dropped: pin high (R7)
        words[1]  = mkw(1, 1, 0, 8'h12, 0);   // both playback, standby kept (R6, R8)
        words[2]  = mkw(0, 0, 0, 8'h5A, 1);   // full record (R3, R4)
        words[3]  = mkw(0, 0, 1, 8'h0F, 0);   // erase (R9)
        words[4]  = mkw(0, 0, 1, 8'hF0, 1);   // erase, polarity flips (R9)
        words[5]  = mkw(1, 0, 0, 8'hFF, 0);   // main playback, aux write (R5)
        words[6]  = mkw(1, 0, 1, 8'h33, 1);   // main playback, aux erase (R5, R9)
        words[7]  = mkw(0, 0, 0, 8'h3C, 0);   // interrupted by pin pulse (R7, R8)
        words[8]  = mkw(0, 0, 0, 8'h00, 0);   // all reverse (R4)
        words[9]  = mkw(0, 1, 0, 8'hC3, 1);   // aux playback (R5)
        words[10] = mkw(1, 1, 1, 8'hFF, 1);   // standby again (R6)
        words[11] = mkw(0, 0, 0, 8'hFF, 1);   // leaves standby (R8)
        words[12] = mkw(0, 0, 1, 8'h81, 0);

        // R1: reset state with the pin low
        repeat (3) @(negedge clk);
        #1;
        checks++;
        if (standby !== 1'b1 || p_en !== '0 || n_en !== '0 || cur_scale !== 2'd0) begin
            errors++;
            $display("FAIL R1 actual p=%b n=%b s=%0d st=%b expected p=0 n=0 s=0 st=1",
                     p_en, n_en, cur_scale, standby);
        end

        @(negedge clk);
        rst_n = 1'b1;
        drive_inputs();
        #1 check_cycle();
        repeat (NWORDS * 32 + 8) begin
            @(negedge clk);
            drive_inputs();
            #1 check_cycle();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule